// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block sits beside a small 8-bit microcontroller core. It decides when the core is held in reset and how the chip moves between normal running, a light sleep state (idle) and a deep sleep state (power-down). A free-running oscillator clock drives it. An asynchronous active-low power-on reset and a raw, unsynchronised reset pin start it. The core asks for a low-power state with single-cycle request pulses. A level input reports that an enabled interrupt is pending.

The block derives the internal clock by dividing the oscillator by two and counts six such states per machine cycle. It marks the last oscillator period of each machine cycle with a one-cycle tick. It produces these outputs:
- clock enables for the CPU, for the peripherals and for the oscillator;
- a synchronous core reset;
- an internal-RAM write inhibit;
- the levels that the external address-latch and program-store strobes are forced to while the core sleeps.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While the oscillator is enabled, `mc_tick` is high for exactly one oscillator cycle in every 12. While the oscillator is stopped, it stays low.
- R2: The reset pin is accepted only after its synchronised level has been high for 24 consecutive oscillator cycles (two machine cycles). A pin pulse of 23 cycles leaves `core_rst` low. A pulse of 24 cycles raises it.
- R3: Once accepted, `core_rst` stays high as long as the pin stays high. It is released only at a machine-cycle tick seen after the pin has gone low.
- R4: While `rst_n` is low, `core_rst` and `ram_wr_inh` are high, and the CPU, peripheral and oscillator enables are high. After `rst_n` is released with the pin low, `core_rst` stays high for 11 oscillator cycles and is low from the 12th.
- R5: An `idle_req` pulse during normal running stops the CPU clock from the next cycle on. The peripheral clock and the oscillator keep running.
- R6: In idle, a pending interrupt brings the CPU clock back one cycle later. Until then, idle persists with no request present.
- R7: A `pd_req` pulse during normal running drops the oscillator, peripheral and CPU enables from the next cycle on. `irq_pend` does not end power-down.
- R8: When `idle_req` and `pd_req` arrive in the same cycle, the block enters power-down.
- R9: In idle, `strb_force`, `ale_lvl` and `psen_lvl` are all 1. In power-down, `strb_force` is 1 and both levels are 0. In running and reset, `strb_force` is 0.
- R10: When the reset pin rises during idle, the CPU clock restarts within three cycles, before the reset is qualified. `ram_wr_inh` is high from that point until the internal reset ends. If the pin falls before it is qualified, idle resumes.
- R11: A reset pin in power-down raises `osc_en` within three cycles. A qualified pulse then passes through reset back to normal running.
- R12: Idle and power-down requests made while `core_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Single-cycle request to enter idle |
| pd_req | input | 1 | Single-cycle request to enter power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Synchronous internal reset for the core |
| ram_wr_inh | output | 1 | Blocks internal RAM writes |
| strb_force | output | 1 | External strobes are forced by this block |
| ale_lvl | output | 1 | Forced level of the address-latch strobe |
| psen_lvl | output | 1 | Forced level of the program-store strobe |
| mc_tick | output | 1 | Last oscillator cycle of a machine cycle |

## Verification
The mode outputs decode a registered state, so a request or interrupt driven before an edge shows at the next falling edge. The bench drives on falling edges and reads one falling edge later. A pin change needs two synchroniser edges before it reaches the state machine, so pin-driven effects are checked three cycles after the pin moves. Acceptance lands on the 26th edge of a 24-cycle pulse. Reset release waits for a machine-cycle tick, which can be up to 12 cycles away. For that reason the bench counts reset rises and ticks in falling-edge monitors and reads the counts after generous waits. The one exception is the release after power-on: the divider phase is known there, so the 11/12-cycle boundary is checked exactly.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [2:0] {
    PM_RST  = 3'd0,
    PM_RUN  = 3'd1,
    PM_IDLE = 3'd2,
    PM_WAKE = 3'd3,
    PM_PD   = 3'd4
  } pm_state_e;
endpackage

// File: rtl/prc_clkdiv.sv
module prc_clkdiv #(
  parameter int STATES_PER_MC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic mc_tick
);
  localparam int SW = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
  localparam logic [SW-1:0] LAST_ST = SW'(STATES_PER_MC - 1);

  logic          ph_q, ph_d;
  logic [SW-1:0] st_q, st_d;

  // divide-by-two phase, then state count within a machine cycle
  always_comb begin
    ph_d = ph_q;
    st_d = st_q;
    if (run_en) begin
      ph_d = ~ph_q;
      if (ph_q) begin
        st_d = (st_q == LAST_ST) ? '0 : st_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      st_q <= '0;
    end else begin
      ph_q <= ph_d;
      st_q <= st_d;
    end
  end

  assign mc_tick = run_en & ph_q & (st_q == LAST_ST);
endmodule

// File: rtl/prc_rst_qual.sv
module prc_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_s,
  output logic accept
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(QUAL_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  logic [CW-1:0] cnt_q, cnt_d;

  // length of the current high run, saturating
  always_comb begin
    if (!pin_s)                cnt_d = '0;
    else if (cnt_q == CNT_SAT) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign accept = pin_s & (cnt_q == CNT_LAST);
endmodule

// File: rtl/prc_mode_fsm.sv
module prc_mode_fsm
  import prc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  logic      rst_acc,
  input  logic      mc_tick,
  input  logic      idle_req,
  input  logic      pd_req,
  input  logic      irq_pend,
  output pm_state_e state
);
  pm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RST: begin
        if (!pin_s && mc_tick) st_d = PM_RUN;
      end
      PM_RUN: begin
        if (rst_acc)       st_d = PM_RST;
        else if (pd_req)   st_d = PM_PD;   // power-down outranks idle
        else if (idle_req) st_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (rst_acc)       st_d = PM_RST;
        else if (pin_s)    st_d = PM_WAKE;
        else if (irq_pend) st_d = PM_RUN;
      end
      PM_WAKE: begin
        if (rst_acc)       st_d = PM_RST;
        else if (!pin_s)   st_d = PM_IDLE;
      end
      PM_PD: begin
        if (rst_acc)       st_d = PM_RST;
      end
      default:             st_d = PM_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PM_RST;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import prc_pkg::*;
#(
  parameter int STATES_PER_MC = 6,
  parameter int QUAL_MC       = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic rst_pin,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pend,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic core_rst,
  output logic ram_wr_inh,
  output logic strb_force,
  output logic ale_lvl,
  output logic psen_lvl,
  output logic mc_tick
);
  localparam int OSC_PER_MC = 2 * STATES_PER_MC;
  localparam int QUAL_CYC   = QUAL_MC * OSC_PER_MC;

  logic      pin_s;
  logic      rst_acc;
  pm_state_e state;

  prc_rst_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYC    (QUAL_CYC)
  ) u_qual (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .pin    (rst_pin),
    .pin_s  (pin_s),
    .accept (rst_acc)
  );

  prc_clkdiv #(
    .STATES_PER_MC (STATES_PER_MC)
  ) u_div (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .run_en  (osc_en),
    .mc_tick (mc_tick)
  );

  prc_mode_fsm u_fsm (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .rst_acc  (rst_acc),
    .mc_tick  (mc_tick),
    .idle_req (idle_req),
    .pd_req   (pd_req),
    .irq_pend (irq_pend),
    .state    (state)
  );

  always_comb begin
    cpu_clk_en = 1'b1;
    per_clk_en = 1'b1;
    osc_en     = 1'b1;
    core_rst   = 1'b0;
    ram_wr_inh = 1'b0;
    strb_force = 1'b0;
    ale_lvl    = 1'b1;
    psen_lvl   = 1'b1;
    unique case (state)
      PM_RST: begin
        core_rst   = 1'b1;
        ram_wr_inh = 1'b1;
      end
      PM_RUN: ;
      PM_IDLE: begin
        cpu_clk_en = 1'b0;
        strb_force = 1'b1;
      end
      PM_WAKE: begin
        ram_wr_inh = 1'b1;
      end
      PM_PD: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = pin_s;   // a pin level restarts the oscillator
        strb_force = 1'b1;
        ale_lvl    = 1'b0;
        psen_lvl   = 1'b0;
      end
      default: begin
        core_rst   = 1'b1;
        ram_wr_inh = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic clk_osc,
  input logic rst_n,
  input logic idle_req,
  input logic pd_req,
  input logic irq_pend,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_en,
  input logic core_rst,
  input logic ram_wr_inh,
  input logic strb_force,
  input logic ale_lvl,
  input logic psen_lvl,
  input logic mc_tick
);
  logic [4:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mc_tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (osc_en) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mc_tick && seen_q) |-> (gap_q == 5'd11));

  // R7
  osc_stop_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !osc_en |-> (!per_clk_en && !cpu_clk_en && !mc_tick));

  // R9
  pd_strobe_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !per_clk_en |-> (strb_force && !ale_lvl && !psen_lvl));

  // R9
  idle_strobe_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en) |-> (strb_force && ale_lvl && psen_lvl));

  // R3
  release_on_tick_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(core_rst) |-> $past(mc_tick));

  // R6
  idle_irq_exit_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && irq_pend) |=> cpu_clk_en);

  // R8
  pd_entry_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (pd_req && cpu_clk_en && !core_rst && !ram_wr_inh) |=> (!per_clk_en || core_rst));

  // R10
  wake_run_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ram_wr_inh && !core_rst) |-> (cpu_clk_en && per_clk_en));

  // R10
  wake_from_idle_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(ram_wr_inh) && !core_rst) |-> $past(!cpu_clk_en));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk u_chk (
  .clk_osc    (clk_osc),
  .rst_n      (rst_n),
  .idle_req   (idle_req),
  .pd_req     (pd_req),
  .irq_pend   (irq_pend),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .core_rst   (core_rst),
  .ram_wr_inh (ram_wr_inh),
  .strb_force (strb_force),
  .ale_lvl    (ale_lvl),
  .psen_lvl   (psen_lvl),
  .mc_tick    (mc_tick)
);

// File: tb/pwr_rst_ctrl_test.sv
`timescale 1ns/1ps
module pwr_rst_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, rst_pin, idle_req, pd_req, irq_pend;
  logic cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_inh;
  logic strb_force, ale_lvl, psen_lvl, mc_tick;

  int total = 0;
  int bad   = 0;
  int ticks = 0;
  int rises = 0;
  int bad_falls = 0;
  logic prev_rst  = 1'b0;
  logic prev_tick = 1'b0;

  always #10 clk = ~clk;

  pwr_rst_ctrl uut (
    .clk_osc(clk), .rst_n(rst_n), .rst_pin(rst_pin),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .core_rst(core_rst), .ram_wr_inh(ram_wr_inh), .strb_force(strb_force),
    .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .mc_tick(mc_tick)
  );

  // falling-edge monitors: tick count, reset rises, releases off a tick (R3)
  always @(negedge clk) begin
    if (mc_tick) ticks <= ticks + 1;
    if (core_rst && !prev_rst) rises <= rises + 1;
    if (!core_rst && prev_rst && rst_n && !prev_tick) bad_falls <= bad_falls + 1;
    prev_rst  <= core_rst;
    prev_tick <= mc_tick;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int h);
    @(negedge clk) rst_pin = 1'b1;
    step(h);
    rst_pin = 1'b0;
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_power_on;
    rst_n = 1'b0; rst_pin = 1'b0; idle_req = 1'b0; pd_req = 1'b0; irq_pend = 1'b0;
    step(5);
    chk("R4 core_rst in por", core_rst, 1);
    chk("R4 ram_wr_inh in por", ram_wr_inh, 1);
    chk("R4 enables in por", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R9 no force in reset", strb_force, 0);
    rst_n = 1'b1;
    step(11);
    chk("R4 held 11 cycles", core_rst, 1);
    step(1);
    chk("R4 released at 12", core_rst, 0);
  endtask

  task automatic t_ticks;
    int t0;
    t0 = ticks;
    step(120);
    chk("R1 ticks per 120 cycles", ticks - t0, 10);
  endtask

  task automatic t_qualify;
    int r0;
    r0 = rises;
    pulse(23);
    step(40);
    chk("R2 23-cycle pulse ignored", rises - r0, 0);
    pulse(24);
    step(40);
    chk("R2 24-cycle pulse accepted", rises - r0, 1);
    chk("R3 released after pin low", core_rst, 0);
    @(negedge clk) rst_pin = 1'b1;
    step(60);
    chk("R3 held while pin high", core_rst, 1);
    rst_pin = 1'b0;
    step(40);
    chk("R3 released", core_rst, 0);
    chk("R3 release only on tick", bad_falls, 0);
  endtask

  task automatic t_idle;
    @(negedge clk) idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    chk("R5 cpu clock stopped", cpu_clk_en, 0);
    chk("R5 per clock and osc run", {per_clk_en, osc_en}, 2'b11);
    chk("R9 idle strobes", {strb_force, ale_lvl, psen_lvl}, 3'b111);
    step(20);
    chk("R6 idle persists", cpu_clk_en, 0);
    irq_pend = 1'b1;
    @(negedge clk) irq_pend = 1'b0;
    chk("R6 irq wakes cpu", cpu_clk_en, 1);
    chk("R9 run no force", strb_force, 0);
  endtask

  task automatic t_idle_reset;
    int r0;
    int miss;
    r0 = rises;
    miss = 0;
    @(negedge clk) idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    // short pin pulse: wake then return to idle
    rst_pin = 1'b1;
    step(3);
    chk("R10 cpu restarts early", cpu_clk_en, 1);
    chk("R10 ram inhibited", ram_wr_inh, 1);
    chk("R10 no core reset yet", core_rst, 0);
    step(7);
    rst_pin = 1'b0;
    step(4);
    chk("R10 back to idle", cpu_clk_en, 0);
    chk("R10 short pulse no reset", rises - r0, 0);
    // full pulse: inhibit held until internal reset ends
    rst_pin = 1'b1;
    step(3);
    for (int i = 0; i < 27; i++) begin
      if (!ram_wr_inh) miss++;
      @(negedge clk);
    end
    rst_pin = 1'b0;
    chk("R10 inhibit held through window", miss, 0);
    chk("R10 reset taken", rises - r0, 1);
    step(40);
    chk("R10 inhibit off in run", ram_wr_inh, 0);
    chk("R10 running after reset", cpu_clk_en, 1);
  endtask

  task automatic t_powerdown;
    int t0;
    int r0;
    r0 = rises;
    @(negedge clk) pd_req = 1'b1;
    @(negedge clk) pd_req = 1'b0;
    chk("R7 enables off", {osc_en, per_clk_en, cpu_clk_en}, 3'b000);
    chk("R9 pd strobes", {strb_force, ale_lvl, psen_lvl}, 3'b100);
    t0 = ticks;
    irq_pend = 1'b1;
    step(30);
    irq_pend = 1'b0;
    chk("R7 no ticks in pd", ticks - t0, 0);
    chk("R7 irq does not exit", osc_en, 0);
    rst_pin = 1'b1;
    step(3);
    chk("R11 osc restarts on pin", osc_en, 1);
    step(27);
    rst_pin = 1'b0;
    step(40);
    chk("R11 reset taken", rises - r0, 1);
    chk("R11 back to run", {cpu_clk_en, per_clk_en, core_rst}, 3'b110);
  endtask

  task automatic t_both_req;
    @(negedge clk) begin idle_req = 1'b1; pd_req = 1'b1; end
    @(negedge clk) begin idle_req = 1'b0; pd_req = 1'b0; end
    chk("R8 pd wins", {osc_en, per_clk_en}, 2'b00);
    pulse(30);
    step(40);
    chk("R8 exit by reset", cpu_clk_en, 1);
  endtask

  task automatic t_req_in_reset;
    @(negedge clk) rst_pin = 1'b1;
    step(30);
    chk("R12 in reset", core_rst, 1);
    idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    pd_req = 1'b1;
    @(negedge clk) pd_req = 1'b0;
    rst_pin = 1'b0;
    step(40);
    chk("R12 requests ignored", {cpu_clk_en, per_clk_en, strb_force}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    t_power_on();
    t_ticks();
    t_qualify();
    t_idle();
    t_idle_reset();
    t_powerdown();
    t_both_req();
    t_req_in_reset();
    finish_up();
  end
endmodule